// File: doc/BRIEF.md
# Power Mode and Start-Up Sequencer

This block decides whether the device runs in normal mode or sleeps, and turns that decision into enables for the surrounding functional blocks. Sleep can be asked for three ways: a write strobe to the dedicated sleep address, a configuration write whose sleep field is 1, or a hardware sleep request pin. The two software paths set a sticky shutdown bit. The pin is ORed with that bit and never alters it, so the pin wins over anything software or a wake event does. An enabled wake event clears the shutdown bit, but only while the pin is low.

The block also sequences start-up. The supply supervisor is enabled out of reset. The clock outputs stay gated until the supervisor reports a good supply and a timeout, counted in 32 kHz ticks, has run out. A drop of the supply-good signal restarts that count. Every analog block enable starts off. Each one has its own software bit, which is ANDed with "not sleeping". I/O pin settings come up as inputs with pull-ups on. The supervisor, the 32 kHz oscillator, the wake mask and the I/O settings keep their values through sleep.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After a synchronous reset: `shdn`=0, `sleep`=0, `blk_en`=0, `sup_en`=1, `osc32_en`=1, `clk_out_en`=0, `clk32_out_en`=0, `io_dir`=0 (all inputs), `io_pu`=all ones, wake mask=0.
- R2: A cycle with `sleep_addr_wr`=1 and `pin_sleep`=0 sets `shdn` to 1 in the next cycle.
- R3: A `cfg_wr` with `cfg_slp`=1 and `pin_sleep`=0 sets `shdn`. A `cfg_wr` with `cfg_slp`=0 leaves `shdn` unchanged.
- R4: While `pin_sleep`=1, `shdn` keeps its value whatever writes or wake events arrive, and `sleep` is 1 in the next cycle.
- R5: `sleep` equals the previous cycle's `pin_sleep` ORed with the current `shdn`. Both are registered from the same inputs, so they have one cycle of latency.
- R6: With `pin_sleep`=0 and no set strobe, a wake event `wake_evt[i]`=1 whose mask bit i (written by `cfg_wr` from `cfg_wake_mask`) is 1 clears `shdn` in the next cycle. Unmasked wake bits have no effect. A set strobe in the same cycle wins over a wake event.
- R7: `blk_en` equals the block control bits (written by `blk_wr`) ANDed with the inverse of the sleep state. The control bits are kept through sleep.
- R8: `sup_en` and `osc32_en` follow `cfg_sup_en`/`cfg_osc_en` on each `cfg_wr`, and `io_dir`/`io_pu` follow `io_wr`. Sleep changes none of them.
- R9: Supply is "ok" when `sup_good`=1 or `sup_en`=0. `clk_out_en` and `clk32_out_en` stay 0 until supply has been ok for TIMEOUT `tick32` cycles. The cycle after supply is not ok, both are 0 and the count restarts from zero.
- R10: Once timed out, `clk_out_en`=1 only while `sleep`=0, and `clk32_out_en`=1 only while `osc32_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_addr_wr | input | 1 | Write strobe to the sleep address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_slp | input | 1 | Configuration sleep field (1 sets shutdown) |
| cfg_sup_en | input | 1 | Configuration supervisor enable |
| cfg_osc_en | input | 1 | Configuration 32 kHz oscillator enable |
| cfg_wake_mask | input | NWAKE | Configuration wake source enables |
| blk_wr | input | 1 | Block control write strobe |
| blk_data | input | NBLK | Block control bits |
| io_wr | input | 1 | I/O settings write strobe |
| io_dir_data | input | NIO | I/O direction bits (1 = output) |
| io_pu_data | input | NIO | I/O pull-up bits |
| pin_sleep | input | 1 | Hardware sleep request |
| sup_good | input | 1 | Supply supervisor reports good supply |
| tick32 | input | 1 | One-cycle pulse per 32 kHz clock period |
| wake_evt | input | NWAKE | Wake event pulses |
| shdn | output | 1 | Software shutdown bit |
| sleep | output | 1 | Sleep state |
| blk_en | output | NBLK | Analog block enables |
| sup_en | output | 1 | Supply supervisor enable |
| osc32_en | output | 1 | 32 kHz oscillator enable |
| clk_out_en | output | 1 | Main clock output enable |
| clk32_out_en | output | 1 | 32 kHz clock output enable |
| io_dir | output | NIO | I/O direction settings |
| io_pu | output | NIO | I/O pull-up settings |

## Verification
The assertions assume that every input is synchronous to `clk` and is held for a whole cycle. They also assume that `tick32` is a single-cycle pulse and that wake events, strobes and the pin request can arrive in any combination, including the same cycle. The stimulus drives all inputs at the falling edge from one process. It draws pin requests, supply drops, ticks, wake events and writes from a fixed-seed generator with varied densities, so that collisions such as a set and a wake in the same cycle, or a write while the pin is held, occur often. It adds directed sequences for the start-up timeout, the restart after a supply drop and the precedence cases.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    SD_KEEP = 2'd0,
    SD_HOLD = 2'd1,
    SD_SET  = 2'd2,
    SD_CLR  = 2'd3
  } shdn_act_e;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pmc_shdn_ctrl.sv
module pmc_shdn_ctrl
  import pmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic pin_sleep,
  input  logic wake_hit,
  output logic shdn_q,
  output logic sleep_q,
  output logic sleep_nx
);
  shdn_act_e act;
  logic      shdn_nx;

  // pin request has top priority, then a set strobe, then a wake
  always_comb begin
    if (pin_sleep)     act = SD_HOLD;
    else if (set_req)  act = SD_SET;
    else if (wake_hit) act = SD_CLR;
    else               act = SD_KEEP;
  end

  always_comb begin
    case (act)
      SD_SET:  shdn_nx = 1'b1;
      SD_CLR:  shdn_nx = 1'b0;
      default: shdn_nx = shdn_q;
    endcase
    sleep_nx = pin_sleep | shdn_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shdn_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      shdn_q  <= shdn_nx;
      sleep_q <= sleep_nx;
    end
  end
endmodule

// File: rtl/pmc_por_timer.sv
module pmc_por_timer
  import pmc_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sup_ok,
  output logic ready_nx
);
  localparam int CW = cnt_width(TIMEOUT);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    if (!sup_ok)                    cnt_nx = '0;
    else if (tick && cnt_q < LIMIT) cnt_nx = cnt_q + 1'b1;
    else                            cnt_nx = cnt_q;
    ready_nx = (cnt_nx == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs #(
  parameter int NWAKE = 2,
  parameter int NBLK  = 6,
  parameter int NIO   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_sup_en,
  input  logic             cfg_osc_en,
  input  logic [NWAKE-1:0] cfg_wake_mask,
  input  logic             blk_wr,
  input  logic [NBLK-1:0]  blk_data,
  input  logic             io_wr,
  input  logic [NIO-1:0]   io_dir_data,
  input  logic [NIO-1:0]   io_pu_data,
  output logic             sup_en_q,
  output logic             osc_q,
  output logic             osc_nx,
  output logic [NWAKE-1:0] mask_q,
  output logic [NBLK-1:0]  blk_nx,
  output logic [NIO-1:0]   io_dir_q,
  output logic [NIO-1:0]   io_pu_q
);
  logic [NBLK-1:0] blk_q;
  logic            sup_nx;
  logic [NWAKE-1:0] mask_nx;

  always_comb begin
    sup_nx  = cfg_wr ? cfg_sup_en    : sup_en_q;
    osc_nx  = cfg_wr ? cfg_osc_en    : osc_q;
    mask_nx = cfg_wr ? cfg_wake_mask : mask_q;
    blk_nx  = blk_wr ? blk_data      : blk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_en_q <= 1'b1;
      osc_q    <= 1'b1;
      mask_q   <= '0;
      blk_q    <= '0;
      io_dir_q <= '0;
      io_pu_q  <= '1;
    end else begin
      sup_en_q <= sup_nx;
      osc_q    <= osc_nx;
      mask_q   <= mask_nx;
      blk_q    <= blk_nx;
      if (io_wr) begin
        io_dir_q <= io_dir_data;
        io_pu_q  <= io_pu_data;
      end
    end
  end
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl #(
  parameter int NWAKE   = 2,
  parameter int NBLK    = 6,
  parameter int NIO     = 4,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_addr_wr,
  input  logic             cfg_wr,
  input  logic             cfg_slp,
  input  logic             cfg_sup_en,
  input  logic             cfg_osc_en,
  input  logic [NWAKE-1:0] cfg_wake_mask,
  input  logic             blk_wr,
  input  logic [NBLK-1:0]  blk_data,
  input  logic             io_wr,
  input  logic [NIO-1:0]   io_dir_data,
  input  logic [NIO-1:0]   io_pu_data,
  input  logic             pin_sleep,
  input  logic             sup_good,
  input  logic             tick32,
  input  logic [NWAKE-1:0] wake_evt,
  output logic             shdn,
  output logic             sleep,
  output logic [NBLK-1:0]  blk_en,
  output logic             sup_en,
  output logic             osc32_en,
  output logic             clk_out_en,
  output logic             clk32_out_en,
  output logic [NIO-1:0]   io_dir,
  output logic [NIO-1:0]   io_pu
);
  logic             osc_nx;
  logic [NWAKE-1:0] wake_mask;
  logic [NBLK-1:0]  blk_nx;
  logic [NBLK-1:0]  blk_gate;
  logic             sleep_nx;
  logic             ready_nx;
  logic             wake_hit;
  logic             set_req;
  logic             sup_ok;

  assign set_req  = sleep_addr_wr | (cfg_wr & cfg_slp);
  assign wake_hit = |(wake_evt & wake_mask);
  assign sup_ok   = sup_good | ~sup_en;

  pmc_cfg_regs #(.NWAKE(NWAKE), .NBLK(NBLK), .NIO(NIO)) i_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_sup_en(cfg_sup_en), .cfg_osc_en(cfg_osc_en),
    .cfg_wake_mask(cfg_wake_mask),
    .blk_wr(blk_wr), .blk_data(blk_data),
    .io_wr(io_wr), .io_dir_data(io_dir_data), .io_pu_data(io_pu_data),
    .sup_en_q(sup_en), .osc_q(osc32_en), .osc_nx(osc_nx),
    .mask_q(wake_mask), .blk_nx(blk_nx),
    .io_dir_q(io_dir), .io_pu_q(io_pu)
  );

  pmc_shdn_ctrl i_shdn (
    .clk(clk), .rst(rst),
    .set_req(set_req), .pin_sleep(pin_sleep), .wake_hit(wake_hit),
    .shdn_q(shdn), .sleep_q(sleep), .sleep_nx(sleep_nx)
  );

  pmc_por_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk(clk), .rst(rst), .tick(tick32), .sup_ok(sup_ok),
    .ready_nx(ready_nx)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_gate[b] = blk_nx[b] & ~sleep_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_en       <= '0;
      clk_out_en   <= 1'b0;
      clk32_out_en <= 1'b0;
    end else begin
      blk_en       <= blk_gate;
      clk_out_en   <= ready_nx & ~sleep_nx;
      clk32_out_en <= ready_nx & osc_nx;
    end
  end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NBLK = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            pin_sleep,
  input logic            sleep_addr_wr,
  input logic            cfg_wr,
  input logic            cfg_slp,
  input logic            wake_hit,
  input logic            sup_en,
  input logic            sup_good,
  input logic            osc32_en,
  input logic            shdn,
  input logic            sleep,
  input logic [NBLK-1:0] blk_en,
  input logic            clk_out_en,
  input logic            clk32_out_en
);
  a_r2_addr_sets: assert property (@(posedge clk) disable iff (rst)
    sleep_addr_wr && !pin_sleep |=> shdn);

  a_r4_pin_holds: assert property (@(posedge clk) disable iff (rst)
    pin_sleep |=> $stable(shdn) && sleep);

  a_r5_sleep_or: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sleep == ($past(pin_sleep) | shdn));

  a_r6_wake_clears: assert property (@(posedge clk) disable iff (rst)
    wake_hit && !pin_sleep && !sleep_addr_wr && !(cfg_wr && cfg_slp) |=> !shdn);

  a_r7_blk_off: assert property (@(posedge clk) disable iff (rst)
    sleep |-> blk_en == '0);

  a_r9_no_supply: assert property (@(posedge clk) disable iff (rst)
    sup_en && !sup_good |=> !clk_out_en && !clk32_out_en);

  a_r10_main_gated: assert property (@(posedge clk) disable iff (rst)
    clk_out_en |-> !sleep);

  a_r10_slow_gated: assert property (@(posedge clk) disable iff (rst)
    clk32_out_en |-> osc32_en);
endmodule

bind pmc_power_ctrl pmc_chk #(.NBLK(NBLK)) i_chk (
  .clk(clk), .rst(rst), .pin_sleep(pin_sleep), .sleep_addr_wr(sleep_addr_wr),
  .cfg_wr(cfg_wr), .cfg_slp(cfg_slp), .wake_hit(wake_hit),
  .sup_en(sup_en), .sup_good(sup_good), .osc32_en(osc32_en),
  .shdn(shdn), .sleep(sleep), .blk_en(blk_en),
  .clk_out_en(clk_out_en), .clk32_out_en(clk32_out_en)
);

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;
  localparam int NWAKE = 2;
  localparam int NBLK  = 6;
  localparam int NIO   = 4;
  localparam int TOUT  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_addr_wr = 0, cfg_wr = 0, cfg_slp = 0, cfg_sup_en = 1, cfg_osc_en = 1;
  logic [NWAKE-1:0] cfg_wake_mask = '0, wake_evt = '0;
  logic blk_wr = 0, io_wr = 0, pin_sleep = 0, sup_good = 0, tick32 = 0;
  logic [NBLK-1:0] blk_data = '0;
  logic [NIO-1:0]  io_dir_data = '0, io_pu_data = '0;
  logic shdn, sleep, sup_en, osc32_en, clk_out_en, clk32_out_en;
  logic [NBLK-1:0] blk_en;
  logic [NIO-1:0]  io_dir, io_pu;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_shdn, m_sleep, m_sup, m_osc, m_ck, m_ck32;
  bit [NWAKE-1:0] m_mask;
  bit [NBLK-1:0]  m_blk, m_blk_en;
  bit [NIO-1:0]   m_dir, m_pu;
  int m_cnt;

  always #10 clk = ~clk;

  pmc_power_ctrl #(.NWAKE(NWAKE), .NBLK(NBLK), .NIO(NIO), .TIMEOUT(TOUT)) i_pmc_power_ctrl (
    .clk(clk), .rst(rst), .sleep_addr_wr(sleep_addr_wr), .cfg_wr(cfg_wr),
    .cfg_slp(cfg_slp), .cfg_sup_en(cfg_sup_en), .cfg_osc_en(cfg_osc_en),
    .cfg_wake_mask(cfg_wake_mask), .blk_wr(blk_wr), .blk_data(blk_data),
    .io_wr(io_wr), .io_dir_data(io_dir_data), .io_pu_data(io_pu_data),
    .pin_sleep(pin_sleep), .sup_good(sup_good), .tick32(tick32), .wake_evt(wake_evt),
    .shdn(shdn), .sleep(sleep), .blk_en(blk_en), .sup_en(sup_en), .osc32_en(osc32_en),
    .clk_out_en(clk_out_en), .clk32_out_en(clk32_out_en), .io_dir(io_dir), .io_pu(io_pu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit next_shdn(bit cur);
    if (pin_sleep) return cur;
    if (sleep_addr_wr || (cfg_wr && cfg_slp)) return 1'b1;
    if (|(wake_evt & m_mask)) return 1'b0;
    return cur;
  endfunction

  task automatic model_update();
    bit sup_ok;
    if (rst) begin
      m_shdn = 0; m_sleep = 0; m_sup = 1; m_osc = 1; m_mask = '0;
      m_blk = '0; m_blk_en = '0; m_dir = '0; m_pu = '1; m_cnt = 0; m_ck = 0; m_ck32 = 0;
      return;
    end
    sup_ok = sup_good || !m_sup;
    m_shdn = next_shdn(m_shdn);
    if (cfg_wr) begin m_sup = cfg_sup_en; m_osc = cfg_osc_en; m_mask = cfg_wake_mask; end
    if (blk_wr) m_blk = blk_data;
    if (io_wr) begin m_dir = io_dir_data; m_pu = io_pu_data; end
    if (!sup_ok) m_cnt = 0;
    else if (tick32 && m_cnt < TOUT) m_cnt++;
    m_sleep  = pin_sleep || m_shdn;
    m_blk_en = m_sleep ? '0 : m_blk;
    m_ck     = (m_cnt == TOUT) && !m_sleep;
    m_ck32   = (m_cnt == TOUT) && m_osc;
  endtask

  task automatic compare();
    chk("R2 shdn", 32'(shdn), 32'(m_shdn));
    chk("R5 sleep", 32'(sleep), 32'(m_sleep));
    chk("R7 blk_en", 32'(blk_en), 32'(m_blk_en));
    chk("R8 sup_en", 32'(sup_en), 32'(m_sup));
    chk("R8 osc32_en", 32'(osc32_en), 32'(m_osc));
    chk("R8 io", 32'({io_dir, io_pu}), 32'({m_dir, m_pu}));
    chk("R9 clk_out_en", 32'(clk_out_en), 32'(m_ck));
    chk("R10 clk32_out_en", 32'(clk32_out_en), 32'(m_ck32));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    sleep_addr_wr = 0; cfg_wr = 0; blk_wr = 0; io_wr = 0; wake_evt = '0; tick32 = 0;
  endtask

  task automatic cfg(input bit slp, input bit se, input bit oe, input bit [NWAKE-1:0] mk);
    cfg_wr = 1; cfg_slp = slp; cfg_sup_en = se; cfg_osc_en = oe; cfg_wake_mask = mk;
  endtask

  initial begin
    #20_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    step(); step();
    // R1: reset state
    chk("R1 shdn", 32'(shdn), 0);
    chk("R1 sleep", 32'(sleep), 0);
    chk("R1 blk_en", 32'(blk_en), 0);
    chk("R1 sup_en/osc32_en", 32'({sup_en, osc32_en}), 32'h3);
    chk("R1 clk outs", 32'({clk_out_en, clk32_out_en}), 0);
    chk("R1 io_dir", 32'(io_dir), 0);
    chk("R1 io_pu", 32'(io_pu), 32'hF);
    rst = 0;
    // R9: start-up timeout with a tick every cycle
    sup_good = 1;
    for (int k = 1; k <= TOUT + 1; k++) begin
      tick32 = 1; step();
      chk("R9 startup", 32'(clk_out_en), 32'(k >= TOUT));
    end
    // R3: slp=0 does not set, slp=1 sets
    cfg(0, 1, 1, 2'b01); step();
    chk("R3 slp0 keeps", 32'(shdn), 0);
    cfg(1, 1, 1, 2'b01); step();
    chk("R3 slp1 sets", 32'(shdn), 1);
    chk("R10 main off in sleep", 32'(clk_out_en), 0);
    chk("R10 slow on in sleep", 32'(clk32_out_en), 1);
    // R6: unmasked wake ignored, masked wake clears
    wake_evt = 2'b10; step();
    chk("R6 unmasked ignored", 32'(shdn), 1);
    wake_evt = 2'b01; step();
    chk("R6 wake clears", 32'({shdn, sleep}), 0);
    // R4: pin wins, shdn untouched
    pin_sleep = 1; sleep_addr_wr = 1; step();
    chk("R4 pin ignores set", 32'({shdn, sleep}), 32'h1);
    pin_sleep = 0; sleep_addr_wr = 1; step();
    pin_sleep = 1; wake_evt = 2'b01; step();
    chk("R4 pin ignores wake", 32'({shdn, sleep}), 32'h3);
    pin_sleep = 0; wake_evt = 2'b01; sleep_addr_wr = 1; step();
    chk("R6 set beats wake", 32'(shdn), 1);
    wake_evt = 2'b01; step();
    // R7: enables retained through sleep
    blk_wr = 1; blk_data = '1; step();
    chk("R7 blk on", 32'(blk_en), 32'h3F);
    sleep_addr_wr = 1; step();
    chk("R7 blk off in sleep", 32'(blk_en), 0);
    wake_evt = 2'b01; step();
    chk("R7 blk restored", 32'(blk_en), 32'h3F);
    // R9: supply drop restarts count
    sup_good = 0; step();
    chk("R9 drop gates", 32'({clk_out_en, clk32_out_en}), 0);
    sup_good = 1;
    for (int k = 1; k <= TOUT; k++) begin
      tick32 = 1; step();
      chk("R9 restart", 32'(clk32_out_en), 32'(k >= TOUT));
    end
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int burst;
      burst = i / 300;
      pin_sleep     = (burst % 3 == 2) ? ($urandom % 4 != 0) : ($urandom % 10 == 0);
      sup_good      = ($urandom % 30 != 0);
      tick32        = ($urandom % 3 == 0);
      wake_evt      = NWAKE'($urandom) & NWAKE'(($urandom % 3 == 0) ? '1 : '0);
      sleep_addr_wr = ($urandom % 12 == 0);
      if ($urandom % 10 == 0) cfg($urandom % 2, $urandom % 8 != 0, $urandom % 4 != 0, NWAKE'($urandom));
      if ($urandom % 10 == 0) begin blk_wr = 1; blk_data = NBLK'($urandom); end
      if ($urandom % 20 == 0) begin io_wr = 1; io_dir_data = NIO'($urandom); io_pu_data = NIO'($urandom); end
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule